// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device end of a parallel ATA register set. A host reaches it through a byte-wide register bus with a 3-bit address and through a separate 16-bit data read port. The block holds the sector count, the three address bytes and the device select byte. It decodes the opcodes written to the command register, reports progress in a status byte and drives an interrupt line.

Four commands are understood:
- IDENTIFY streams 256 words out of the data port under a per-word ready handshake. The words are computed from two text parameters, a serial string and a firmware string.
- FLUSH CACHE keeps the device busy until an external completion pulse arrives.
- READ DMA and WRITE DMA are handed to a separate DMA engine. The block raises a request that carries the direction, the 24-bit address and the count, and waits for that engine's done pulse.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40 (ready only), `irq`, `flush_req` and `dma_req` are low, and every task-file register reads zero.
- R2: When the device is idle, bytes written at offsets 2 (count), 3, 4, 5 (address low, middle, high) and 6 (device select) read back unchanged at the same offsets. Offsets 0 and 1 read 0x00. Status is read at offset 7. Status bits are: busy 0x80, ready 0x40, fault 0x20, data request 0x08, error 0x01.
- R3: Writing 0xEC at offset 7 starts IDENTIFY. Before each of the 256 data reads, status reads 0x48. After the 256th read, status reads 0x40.
- R4: Identify word `w` is built as follows. Words 10–19 hold the 20-character serial parameter. Words 23–26 hold the 8-character version parameter. In both, character 2k goes in the high byte and character 2k+1 in the low byte. Word 85 reads 0x0020. Every other word reads 0x0000.
- R5: `irq` is raised when IDENTIFY data becomes ready, when a flush or a DMA transfer finishes, and when an opcode is rejected. A read of offset 7 lowers `irq` in the next cycle. If a raise and such a read fall in the same cycle, the raise wins.
- R6: Writing 0xE7 raises `flush_req` and makes status read 0xC0. A `flush_done` pulse then lowers `flush_req`, returns status to 0x40 and raises `irq`.
- R7: Writing 0xC8 (read) or 0xCA (write) raises `dma_req`. At the same time, `dma_dir` is 1 for 0xC8 and 0 for 0xCA, `dma_lba` is {high, middle, low}, `dma_count` is the count byte, and status reads 0xC0. A `dma_done` pulse returns status to 0x40 and raises `irq`.
- R8: Any other opcode leaves the device idle, makes status read 0x41 and raises `irq`. The next accepted command clears the error bit.
- R9: While busy or in a data transfer, writes to offsets 2–7 are ignored. Neither the register contents nor the command in progress change.
- R10: A `flush_done` or `dma_done` pulse that arrives when no matching operation is running has no effect on status or `irq`.
- R11: `data_rdata` reads 0x0000 when no data transfer is pending. A data read strobe at that time does not move the identify word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at offset 7 clears `irq`) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| data_rd | input | 1 | 16-bit data port read strobe |
| data_rdata | output | 16 | Current identify word |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Flush in progress, waiting for completion |
| flush_done | input | 1 | Flush completion pulse |
| dma_req | output | 1 | DMA transfer requested |
| dma_dir | output | 1 | 1 = device to memory, 0 = memory to device |
| dma_lba | output | 24 | Transfer start address |
| dma_count | output | 8 | Transfer sector count |
| dma_done | input | 1 | DMA completion pulse |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a completion pulse. The interrupt-clear and interrupt-raise paths collide there, and the host can only see the outcome one cycle later. The bench sets `dma_done` and the status read strobe on the same falling edge, then samples `irq` after the next rising edge. The bench also sweeps all 256 identify words, checking each word against characters it pulls independently from its own copies of the strings.

// File: rtl/atf_pkg.sv
package atf_pkg;
  localparam int SER_CHARS = 20;
  localparam int VER_CHARS = 8;
  localparam int SER_BITS  = SER_CHARS * 8;
  localparam int VER_BITS  = VER_CHARS * 8;
  localparam int SER_FIRST = 10;
  localparam int VER_FIRST = 23;
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int VER_WORDS = VER_CHARS / 2;
  localparam int CAPS_WORD = 85;
  localparam int ID_WORDS  = 256;
  localparam int IDX_W     = $clog2(ID_WORDS);
  localparam int TF_REGS   = 5;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] OP_RDDMA = 8'hC8;
  localparam logic [7:0] OP_WRDMA = 8'hCA;

  localparam logic [7:0] SB_BUSY  = 8'h80;
  localparam logic [7:0] SB_READY = 8'h40;
  localparam logic [7:0] SB_XFER  = 8'h08;
  localparam logic [7:0] SB_ERROR = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_PIO, ST_FLUSH, ST_DMA} seq_state_t;

  function automatic logic [7:0] status_byte(seq_state_t st, logic err);
    case (st)
      ST_PIO:   return SB_READY | SB_XFER;
      ST_FLUSH: return SB_BUSY | SB_READY;
      ST_DMA:   return SB_BUSY | SB_READY;
      default:  return SB_READY | (err ? SB_ERROR : 8'h00);
    endcase
  endfunction

  function automatic logic [15:0] id_word(logic [IDX_W-1:0] idx,
                                          logic [SER_BITS-1:0] ser,
                                          logic [VER_BITS-1:0] ver);
    int w;
    int k;
    w = int'(idx);
    if (w >= SER_FIRST && w < SER_FIRST + SER_WORDS) begin
      k = w - SER_FIRST;
      return ser[SER_BITS-1-16*k -: 16];
    end else if (w >= VER_FIRST && w < VER_FIRST + VER_WORDS) begin
      k = w - VER_FIRST;
      return ver[VER_BITS-1-16*k -: 16];
    end else if (w == CAPS_WORD) begin
      return 16'h0020;
    end
    return 16'h0000;
  endfunction
endpackage

// File: rtl/atf_taskfile.sv
module atf_taskfile
  import atf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] regs [TF_REGS]
);
  for (genvar i = 0; i < TF_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (addr == 3'(i + 2));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= 8'h00;
      else if (hit) regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/atf_seq.sv
module atf_seq
  import atf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_code,
  input  logic             status_rd,
  input  logic             data_rd,
  input  logic             flush_done,
  input  logic             dma_done,
  output seq_state_t       state,
  output logic [IDX_W-1:0] word_idx,
  output logic             err,
  output logic             irq,
  output logic             dir_in,
  output logic             irq_set,
  output logic             last_read
);
  logic accept, start_pio, start_flush, start_dma, bad_cmd, cmd_end;

  always_comb begin
    accept      = cmd_we && (state == ST_IDLE);
    start_pio   = accept && (cmd_code == OP_IDENT);
    start_flush = accept && (cmd_code == OP_FLUSH);
    start_dma   = accept && (cmd_code == OP_RDDMA || cmd_code == OP_WRDMA);
    bad_cmd     = accept && !start_pio && !start_flush && !start_dma;
    cmd_end     = (state == ST_FLUSH && flush_done) || (state == ST_DMA && dma_done);
    last_read   = (state == ST_PIO) && data_rd && (word_idx == IDX_W'(ID_WORDS - 1));
    irq_set     = start_pio || cmd_end || bad_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_idx <= '0;
      err      <= 1'b0;
      irq      <= 1'b0;
      dir_in   <= 1'b0;
    end else begin
      if (irq_set)        irq <= 1'b1;
      else if (status_rd) irq <= 1'b0;

      if (bad_cmd)     err <= 1'b1;
      else if (accept) err <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start_pio) begin
            state    <= ST_PIO;
            word_idx <= '0;
          end else if (start_flush) begin
            state <= ST_FLUSH;
          end else if (start_dma) begin
            state  <= ST_DMA;
            dir_in <= (cmd_code == OP_RDDMA);
          end
        end
        ST_PIO: if (data_rd) begin
          word_idx <= word_idx + 1'b1;
          if (last_read) state <= ST_IDLE;
        end
        ST_FLUSH: if (flush_done) state <= ST_IDLE;
        ST_DMA:   if (dma_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import atf_pkg::*;
#(
  parameter logic [SER_BITS-1:0] SERIAL_TXT  = "TESTDISK            ",
  parameter logic [VER_BITS-1:0] VERSION_TXT = "REV 2.10"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        data_rd,
  output logic [15:0] data_rdata,
  output logic        irq,
  output logic        flush_req,
  input  logic        flush_done,
  output logic        dma_req,
  output logic        dma_dir,
  output logic [23:0] dma_lba,
  output logic [7:0]  dma_count,
  input  logic        dma_done
);
  seq_state_t       state;
  logic [IDX_W-1:0] word_idx;
  logic             err, irq_set, last_read, tf_we, cmd_we, status_rd;
  logic [7:0]       status;
  logic [7:0]       tf [TF_REGS];

  assign tf_we     = reg_wr && (state == ST_IDLE) && (reg_addr >= 3'd2) && (reg_addr <= 3'd6);
  assign cmd_we    = reg_wr && (reg_addr == 3'd7);
  assign status_rd = reg_rd && (reg_addr == 3'd7);

  atf_taskfile u_tf (
    .clk(clk), .rst_n(rst_n), .wr_en(tf_we), .addr(reg_addr),
    .wdata(reg_wdata), .regs(tf)
  );

  atf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(reg_wdata),
    .status_rd(status_rd), .data_rd(data_rd), .flush_done(flush_done),
    .dma_done(dma_done), .state(state), .word_idx(word_idx), .err(err),
    .irq(irq), .dir_in(dma_dir), .irq_set(irq_set), .last_read(last_read)
  );

  assign status     = status_byte(state, err);
  assign flush_req  = (state == ST_FLUSH);
  assign dma_req    = (state == ST_DMA);
  assign dma_count  = tf[0];
  assign dma_lba    = {tf[3], tf[2], tf[1]};
  assign data_rdata = (state == ST_PIO) ? id_word(word_idx, SERIAL_TXT, VERSION_TXT) : 16'h0000;

  always_comb begin
    case (reg_addr)
      3'd2, 3'd3, 3'd4, 3'd5, 3'd6: reg_rdata = tf[int'(reg_addr) - 2];
      3'd7:                         reg_rdata = status;
      default:                      reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/atf_checker.sv
module atf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       irq,
  input logic       status_rd,
  input logic       irq_set,
  input logic       flush_req,
  input logic       dma_req,
  input logic       dma_dir,
  input logic       last_read
);
  // R3
  busy_xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));
  // R3
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_read |=> (!status[3] && status[6]));
  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_set) |=> !irq);
  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_set) |=> !irq);
  // R6
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (status[7] && !status[3]));
  // R7
  dma_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> (!dma_req || $stable(dma_dir)));
endmodule

bind ata_taskfile_ctrl atf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .irq(irq), .status_rd(status_rd),
  .irq_set(irq_set), .flush_req(flush_req), .dma_req(dma_req),
  .dma_dir(dma_dir), .last_read(last_read)
);

// File: tb/ata_taskfile_ctrl_test.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_test;
  localparam string SER_S = "TESTDISK            ";
  localparam string VER_S = "REV 2.10";
  localparam logic [159:0] SER_V = "TESTDISK            ";
  localparam logic [63:0]  VER_V = "REV 2.10";

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0, data_rd = 0, flush_done = 0, dma_done = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, dma_count;
  logic [15:0] data_rdata;
  logic irq, flush_req, dma_req, dma_dir;
  logic [23:0] dma_lba;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_taskfile_ctrl #(.SERIAL_TXT(SER_V), .VERSION_TXT(VER_V)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_rd(data_rd),
    .data_rdata(data_rdata), .irq(irq), .flush_req(flush_req), .flush_done(flush_done),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_lba(dma_lba), .dma_count(dma_count),
    .dma_done(dma_done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #0.5 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_done = 1; @(negedge clk); flush_done = 0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_done = 1; @(negedge clk); dma_done = 0;
  endtask

  function automatic logic [15:0] exp_word(int w);
    if (w >= 10 && w <= 19) return {SER_S[2*(w-10)], SER_S[2*(w-10)+1]};
    if (w >= 23 && w <= 26) return {VER_S[2*(w-23)], VER_S[2*(w-23)+1]};
    if (w == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w0;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    peek(3'd7, v); chk("R1 status", v, 8'h40);
    chk("R1 irq", irq, 0); chk("R1 flush_req", flush_req, 0); chk("R1 dma_req", dma_req, 0);
    for (int a = 2; a <= 6; a++) begin peek(3'(a), v); chk("R1 tf zero", v, 0); end
    // R11 idle data port
    chk("R11 idle data", data_rdata, 0);
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
    // R2 readback sweep over several patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 2; a <= 6; a++) wr(3'(a), 8'((a * 37 + p * 91) ^ 8'h5A));
      for (int a = 2; a <= 6; a++) begin
        peek(3'(a), v); chk("R2 readback", v, 8'((a * 37 + p * 91) ^ 8'h5A));
      end
    end
    peek(3'd0, v); chk("R2 offset0", v, 0);
    peek(3'd1, v); chk("R2 offset1", v, 0);
    wr(3'd6, 8'h40);
    peek(3'd6, v); chk("R2 device0 bit clear", v & 8'h10, 0);
    // R3/R4 identify sweep
    wr(3'd7, 8'hEC);
    chk("R5 irq on identify", irq, 1);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, v); chk("R3 status per word", v, 8'h48);
      if (i == 0) chk("R5 status read clears irq", irq, 0);
      @(negedge clk); data_rd = 1; #0.5 w0 = data_rdata;
      chk("R4 identify word", w0, exp_word(i));
      if (i == 0) begin
        // R11 reads in idle did not advance position: word 0 seen first
        chk("R11 position kept", w0, exp_word(0));
      end
      @(negedge clk); data_rd = 0;
    end
    peek(3'd7, v); chk("R3 after last word", v, 8'h40);
    chk("R11 data after pio", data_rdata, 0);
    // R6 flush with R9 ignored writes
    wr(3'd2, 8'h11);
    wr(3'd7, 8'hE7);
    peek(3'd7, v); chk("R6 flush busy status", v, 8'hC0);
    chk("R6 flush_req", flush_req, 1);
    wr(3'd2, 8'h77); wr(3'd7, 8'hEC);
    peek(3'd7, v); chk("R9 still flushing", v, 8'hC0);
    pulse_dma();
    peek(3'd7, v); chk("R10 stray dma_done in flush", v, 8'hC0);
    pulse_flush();
    peek(3'd7, v); chk("R6 flush complete", v, 8'h40);
    chk("R6 flush_req low", flush_req, 0); chk("R5 irq on flush end", irq, 1);
    peek(3'd2, v); chk("R9 count unchanged", v, 8'h11);
    rd(3'd7, v); chk("R5 irq cleared", irq, 0);
    // R10 stray completions in idle
    pulse_flush(); pulse_dma();
    chk("R10 no irq", irq, 0);
    peek(3'd7, v); chk("R10 status idle", v, 8'h40);
    // R7 DMA read and write
    wr(3'd2, 8'h08); wr(3'd3, 8'h21); wr(3'd4, 8'h43); wr(3'd5, 8'h65);
    wr(3'd7, 8'hC8);
    chk("R7 dma_req", dma_req, 1); chk("R7 dir read", dma_dir, 1);
    chk("R7 lba", dma_lba, 24'h654321); chk("R7 count", dma_count, 8'h08);
    peek(3'd7, v); chk("R7 busy status", v, 8'hC0);
    // R5 completion and status read in the same cycle: raise wins
    @(negedge clk); dma_done = 1; reg_addr = 3'd7; reg_rd = 1;
    @(negedge clk); dma_done = 0; reg_rd = 0;
    chk("R5 raise wins", irq, 1);
    peek(3'd7, v); chk("R7 dma complete", v, 8'h40);
    chk("R7 dma_req low", dma_req, 0);
    rd(3'd7, v);
    wr(3'd7, 8'hCA);
    chk("R7 dir write", dma_dir, 0); chk("R7 dma_req write", dma_req, 1);
    pulse_dma();
    chk("R5 irq on dma end", irq, 1);
    rd(3'd7, v);
    // R8 unknown opcodes
    for (int c = 0; c < 3; c++) begin
      wr(3'd7, c == 0 ? 8'h00 : (c == 1 ? 8'h20 : 8'hFF));
      peek(3'd7, v); chk("R8 error status", v, 8'h41);
      chk("R8 irq", irq, 1);
      rd(3'd7, v);
    end
    wr(3'd7, 8'hE7);
    pulse_flush();
    peek(3'd7, v); chk("R8 error cleared", v, 8'h40);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule